// File: doc/BRIEF.md
# Bit-Queue JTAG Master with Even TCK Divider

This block drives a remote test access port from a queue of bits. A requester
offers a word of TMS values, a word of TDI values, a bit count and a half-period
setting, then pulses a start strobe. The master produces a TCK whose period is
always an even number of system clock cycles. It presents each TMS/TDI pair
least significant bit first, collects the target's TDO into a result word, and
raises a one-cycle completion pulse once the last bit has been clocked.

TCK is the registered high/low phase flag of the control state machine, so no
logic sits between a flop and the clock pin. Outgoing bits change when TCK
falls, or when a transfer starts. TDO is sampled when TCK rises, a full
half-period after the target has had its falling edge to update it. A board
with two target ports uses two instances, each with its own request interface
and its own TCK, TMS, TDI and TDO pins.

Top module: `jtag_bitq_master`

## Requirements
- R1: After reset, `tck`, `tms`, `tdi` and `done` are 0, `tdoWord` is all zeros, and `tck` stays 0 whenever no transfer is running.
- R2: During a transfer of n bits with effective half-period h, TCK is low for h system cycles and then high for h cycles, n times in a row. The first low phase starts in the cycle after the accepted start, and exactly n rising edges occur.
- R3: A `halfDiv` value of 0 or 1 acts as 2, so the divide ratio is never below 4 and every TCK high or low phase lasts at least 2 cycles.
- R4: The bit shifted out on TMS and TDI before rising edge i (i counted from 0) is bit i of `tmsWord` and `tdiWord` as captured at start. Both pins change only while TCK is low, which happens at start or at a falling edge. They hold steady throughout each high phase.
- R5: `tdoIn`, sampled at rising edge i, is stored in `tdoWord[i]`. Bits at and above n read 0. The word is cleared when a transfer is accepted.
- R6: `done` is high for exactly one cycle, the cycle after the last high phase ends. In that cycle TCK is already low, and no other cycle of the transfer shows `done`.
- R7: A start pulse while a transfer is running is ignored, along with the word, count and divider values offered with it. The running transfer keeps its timing, its bits and its result.
- R8: A `bitCount` of 0 runs one bit, and a `bitCount` above 32 runs 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start strobe, taken only when idle |
| tmsWord | input | 32 | TMS bits, bit 0 goes first |
| tdiWord | input | 32 | TDI bits, bit 0 goes first |
| bitCount | input | 6 | Number of bits to shift (1 to 32, clamped) |
| halfDiv | input | 8 | TCK half-period in system cycles (minimum 2) |
| tdoIn | input | 1 | Serial data returned by the target |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target |
| tdoWord | output | 32 | Collected TDO bits, bit 0 first |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The hardest case to reach is a start pulse that arrives in the middle of a
transfer and carries different words, count and divider. It has to leave
every later edge and every collected bit untouched. The bench raises that
pulse a few cycles into a running transfer, with inverted words and another
divider, and then compares the full TCK waveform, the bits latched at each
rising edge and the result word against the original request. The bench also
models the target. It presents a new TDO bit after every TCK fall that it
observes, so that any mismatch between sampling edge and bit index shows up in
the result word.

// File: rtl/jtagq_pkg.sv
package jtagq_pkg;
  // Per-cycle commands from the control FSM to the shift datapath.
  typedef struct packed {
    logic load;     // accept a new request
    logic shift;    // TCK falling edge: present next bit
    logic capture;  // TCK rising edge: sample TDO
  } dpStrobe_t;
endpackage

// File: rtl/jtagq_ctrl.sv
module jtagq_ctrl
  import jtagq_pkg::*;
#(
  parameter int DataWidth = 32,
  parameter int CntWidth  = $clog2(DataWidth + 1),
  parameter int DivWidth  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [CntWidth-1:0] bitCount,
  input  logic [DivWidth-1:0] halfDiv,
  output dpStrobe_t           strobe,
  output logic                tck,
  output logic                busy,
  output logic                done
);
  localparam logic [CntWidth-1:0] MaxBits = CntWidth'(DataWidth);
  localparam logic [CntWidth-1:0] OneBit  = CntWidth'(1);
  localparam logic [DivWidth-1:0] MinHalf = DivWidth'(2);
  localparam logic [DivWidth-1:0] OneDiv  = DivWidth'(1);

  logic                busyQ, highQ, doneQ;
  logic [DivWidth-1:0] phaseCnt, halfQ, halfEff;
  logic [CntWidth-1:0] bitsLeft, countEff;
  logic                phaseEnd, lastBit;

  always_comb begin
    halfEff  = (halfDiv < MinHalf) ? MinHalf : halfDiv;
    if (bitCount == '0)          countEff = OneBit;
    else if (bitCount > MaxBits) countEff = MaxBits;
    else                         countEff = bitCount;
    phaseEnd = (phaseCnt == '0);
    lastBit  = (bitsLeft == OneBit);
  end

  always_comb begin
    strobe.load    = !busyQ && startReq;
    strobe.capture = busyQ && !highQ && phaseEnd;
    strobe.shift   = busyQ && highQ && phaseEnd && !lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      highQ    <= 1'b0;
      doneQ    <= 1'b0;
      phaseCnt <= '0;
      halfQ    <= MinHalf;
      bitsLeft <= '0;
    end else begin
      doneQ <= busyQ && highQ && phaseEnd && lastBit;
      if (strobe.load) begin
        busyQ    <= 1'b1;
        highQ    <= 1'b0;
        phaseCnt <= halfEff - OneDiv;
        halfQ    <= halfEff;
        bitsLeft <= countEff;
      end else if (busyQ) begin
        if (phaseEnd) begin
          phaseCnt <= halfQ - OneDiv;
          if (!highQ) begin
            highQ <= 1'b1;
          end else begin
            highQ <= 1'b0;
            if (lastBit) busyQ <= 1'b0;
            else         bitsLeft <= bitsLeft - OneBit;
          end
        end else begin
          phaseCnt <= phaseCnt - OneDiv;
        end
      end
    end
  end

  assign tck  = highQ;
  assign busy = busyQ;
  assign done = doneQ;
endmodule

// File: rtl/jtagq_datapath.sv
module jtagq_datapath
  import jtagq_pkg::*;
#(
  parameter int DataWidth = 32,
  parameter int IdxWidth  = $clog2(DataWidth)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [DataWidth-1:0] tmsWord,
  input  logic [DataWidth-1:0] tdiWord,
  input  logic                 tdoIn,
  output logic                 tms,
  output logic                 tdi,
  output logic [DataWidth-1:0] tdoWord
);
  logic [DataWidth-1:0] tmsSh, tdiSh, tdoQ;
  logic [IdxWidth-1:0]  capIdx;
  logic                 tmsQ, tdiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmsSh  <= '0;
      tdiSh  <= '0;
      tdoQ   <= '0;
      capIdx <= '0;
      tmsQ   <= 1'b0;
      tdiQ   <= 1'b0;
    end else if (strobe.load) begin
      tmsQ   <= tmsWord[0];
      tdiQ   <= tdiWord[0];
      tmsSh  <= tmsWord >> 1;
      tdiSh  <= tdiWord >> 1;
      tdoQ   <= '0;
      capIdx <= '0;
    end else begin
      if (strobe.shift) begin
        tmsQ  <= tmsSh[0];
        tdiQ  <= tdiSh[0];
        tmsSh <= tmsSh >> 1;
        tdiSh <= tdiSh >> 1;
      end
      if (strobe.capture) begin
        tdoQ[capIdx] <= tdoIn;
        capIdx       <= capIdx + IdxWidth'(1);
      end
    end
  end

  assign tms     = tmsQ;
  assign tdi     = tdiQ;
  assign tdoWord = tdoQ;
endmodule

// File: rtl/jtag_bitq_master.sv
module jtag_bitq_master
  import jtagq_pkg::*;
#(
  parameter int DataWidth = 32,
  parameter int DivWidth  = 8,
  localparam int CntWidth = $clog2(DataWidth + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [DataWidth-1:0] tmsWord,
  input  logic [DataWidth-1:0] tdiWord,
  input  logic [CntWidth-1:0]  bitCount,
  input  logic [DivWidth-1:0]  halfDiv,
  input  logic                 tdoIn,
  output logic                 tck,
  output logic                 tms,
  output logic                 tdi,
  output logic [DataWidth-1:0] tdoWord,
  output logic                 done
);
  dpStrobe_t strobeW;
  logic      busyW;

  jtagq_ctrl #(
    .DataWidth(DataWidth), .CntWidth(CntWidth), .DivWidth(DivWidth)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .bitCount(bitCount),
    .halfDiv(halfDiv), .strobe(strobeW), .tck(tck), .busy(busyW), .done(done)
  );

  jtagq_datapath #(
    .DataWidth(DataWidth)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobeW), .tmsWord(tmsWord),
    .tdiWord(tdiWord), .tdoIn(tdoIn), .tms(tms), .tdi(tdi), .tdoWord(tdoWord)
  );
endmodule

// File: rtl/jtag_bitq_master_chk.sv
module jtag_bitq_master_chk (
  input logic clk,
  input logic rstN,
  input logic tck,
  input logic tms,
  input logic tdi,
  input logic done,
  input logic busy
);
  a_r1_idle_tck_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tck);

  a_r4_hold_while_high: assert property (@(posedge clk) disable iff (!rstN)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

  a_r4_change_when_low: assert property (@(posedge clk) disable iff (!rstN)
    (tms != $past(tms) || tdi != $past(tdi)) |-> !tck);

  a_r3_min_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tck) |=> tck);

  a_r3_min_low: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(tck) && busy) |=> !tck);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !tck));
endmodule

bind jtag_bitq_master jtag_bitq_master_chk u_chk (
  .clk(clk), .rstN(rstN), .tck(tck), .tms(tms), .tdi(tdi),
  .done(done), .busy(busyW)
);

// File: tb/jtag_bitq_master_bench.sv
`timescale 1ns/1ps
module jtag_bitq_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] tmsWord = '0, tdiWord = '0;
  logic [5:0]  bitCount = '0;
  logic [7:0]  halfDiv = '0;
  logic        tdoIn = 1'b0;
  logic        tck, tms, tdi, done;
  logic [31:0] tdoWord;

  int totalCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  jtag_bitq_master u_jtag_bitq_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tmsWord(tmsWord),
    .tdiWord(tdiWord), .bitCount(bitCount), .halfDiv(halfDiv), .tdoIn(tdoIn),
    .tck(tck), .tms(tms), .tdi(tdi), .tdoWord(tdoWord), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runXfer(input int h, input int cntIn, input logic [31:0] tmsW,
                         input logic [31:0] tdiW, input logic [31:0] tdoPat,
                         input bit glitch);
    int hEff = (h < 2) ? 2 : h;
    int n = (cntIn == 0) ? 1 : ((cntIn > 32) ? 32 : cntIn);
    int per = 2 * hEff;
    int total = per * n;
    logic [31:0] mask = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    logic [31:0] rxTms = '0, rxTdi = '0;
    int rise = 0, fall = 0, badCycles = 0;
    bit doneOk = 1'b1;
    logic prevTck = 1'b0;
    bit expTck;
    string shapeReq = (h < 2) ? "R3" : "R2";

    @(negedge clk);
    tmsWord = tmsW; tdiWord = tdiW; bitCount = cntIn[5:0];
    halfDiv = h[7:0]; tdoIn = tdoPat[0]; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int c = 1; c <= total + 1; c++) begin
      if (c > 1) @(negedge clk);
      expTck = (c <= total) && (((c - 1) % per) >= hEff);
      if (tck !== expTck) badCycles++;
      if (c <= total && done) doneOk = 1'b0;
      if (c == total + 1 && done !== 1'b1) doneOk = 1'b0;
      if (tck && !prevTck) begin
        if (rise < 32) begin rxTms[rise] = tms; rxTdi[rise] = tdi; end
        rise++;
      end
      if (!tck && prevTck) begin
        fall++;
        tdoIn = tdoPat[fall % 32];
      end
      if (glitch && c == 3) begin
        startReq = 1'b1; tmsWord = ~tmsW; tdiWord = ~tdiW;
        bitCount = 6'd3; halfDiv = 8'd9;
      end
      if (glitch && c == 4) startReq = 1'b0;
      prevTck = tck;
    end
    check(badCycles == 0, shapeReq, "tck waveform mismatching cycles", badCycles, 0);
    check(rise == n, (cntIn == 0 || cntIn > 32) ? "R8" : "R2", "rising edge count", rise, n);
    check(rxTms == (tmsW & mask), "R4", "tms bits at rising edges", rxTms, tmsW & mask);
    check(rxTdi == (tdiW & mask), "R4", "tdi bits at rising edges", rxTdi, tdiW & mask);
    check(tdoWord === (tdoPat & mask), "R5", "collected tdo word", tdoWord, tdoPat & mask);
    check(doneOk, "R6", "done timing", doneOk, 1);
    @(negedge clk);
    check(done === 1'b0 && tck === 1'b0, "R6", "done pulse width / tck idle",
          {30'd0, done, tck}, 0);
    if (glitch)
      check(badCycles == 0 && rxTms == (tmsW & mask) && tdoWord === (tdoPat & mask),
            "R7", "start during transfer disturbed it", tdoWord, tdoPat & mask);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(tck === 1'b0 && tms === 1'b0 && tdi === 1'b0 && done === 1'b0,
          "R1", "pin state in reset", {28'd0, tck, tms, tdi, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(tck === 1'b0 && done === 1'b0 && tdoWord === '0, "R1",
          "idle after reset", tdoWord, 0);
    begin
      int halves[5] = '{0, 1, 2, 3, 4};
      int counts[6] = '{1, 5, 32, 0, 45, 17};
      for (int hi = 0; hi < 5; hi++) begin
        for (int ci = 0; ci < 6; ci++) begin
          int k = hi * 6 + ci + 1;
          logic [31:0] a = 32'h9E37_79B9 * k;
          logic [31:0] b = {a[12:0], a[31:13]} ^ 32'h5A5A_0F0F;
          logic [31:0] t = ~(a ^ (b << 3));
          runXfer(halves[hi], counts[ci], a, b, t, 1'b0);
        end
      end
    end
    runXfer(2, 32, 32'hF0F0_1234, 32'h0F0F_ABCD, 32'hC3A5_9669, 1'b1);
    runXfer(3, 12, 32'h0000_0AAA, 32'h0000_0555, 32'hFFFF_F00F, 1'b1);
    runXfer(5, 32, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 1'b0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end
endmodule